// File: doc/BRIEF.md
# Scatter-Gather Chain Walker

The walker turns a linked table of buffer entries in memory into a stream of address and length pairs for a data mover. Software places a table of 8-byte entries in memory, gives the walker the table's base address and pulses `start`. The walker then reads each entry, one 32-bit word at a time, over a simple request/response read port. For every usable entry it offers one segment to the data mover with a valid/ready handshake. It stops after the entry marked as the last one. A chip carries one walker for the transmit direction and one for the receive direction. The movement of the data itself happens elsewhere.

The first word of an entry holds the flags and the length. The second word holds the buffer address. An entry can also mark the table as a ring. In that case the walker returns to the table base after the last entry instead of stopping, and it keeps cycling until it is told to abort. An entry that is not marked valid stops the walker with an error, and so does an entry whose length is larger than a single segment may be. An entry of length zero produces no segment.

Top module: `sg_chain_walker`

## Requirements
- R1: After reset, `busy`, `rd_req_valid`, `seg_valid`, `done`, `err_invalid` and `err_oversize` are all 0.
- R2: A `start` pulse while idle captures `table_base`, which must be 8-byte aligned. Entry k is read at `table_base + 8k`: first the word at offset 0, then the word at offset 4, with one read in flight at a time. `rd_req_addr` holds steady while `rd_req_valid` waits for `rd_req_ready`.
- R3: First-word layout: bit 0 valid, bit 1 last, bit 2 interrupt request, bits 5:3 action code, bit 6 ring, bit 7 reserved, bits 31:8 length in bytes. A segment carries the second word on `seg_addr`, the length on `seg_len`, bit 2 on `seg_irq`, bits 5:3 on `seg_action` and bit 1 on `seg_end`.
- R4: A segment stays on the outputs, unchanged, until `seg_ready` takes it. No read of the next entry starts before that.
- R5: After the last entry (ring clear) has been taken or skipped, `done` pulses for one cycle and `busy` is 0 in that cycle.
- R6: An entry with bit 0 clear, or with the reserved bit 7 set, produces no segment. It pulses `err_invalid` for one cycle and returns the walker to idle without further reads.
- R7: An entry longer than `MAX_SEG` bytes (default 0x100000) pulses `err_oversize` and stops the walker like R6. A length of exactly `MAX_SEG` is passed on as a normal segment.
- R8: A valid entry of length 0 produces no segment. The walker moves straight to the next entry, or it ends as in R5 if that entry is the last one.
- R9: A last entry that has the ring bit set sends the walker back to the captured table base, and the walk goes on from entry 0.
- R10: `abort` while busy lets the current entry finish. `done` then pulses and no further read is issued.
- R11: `start` is ignored while the walker is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk at `table_base` (idle only) |
| abort | input | 1 | Finish after the current entry |
| table_base | input | ADDR_W | Byte address of entry 0 |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse: walk ended normally |
| err_invalid | output | 1 | One-cycle pulse: invalid entry met |
| err_oversize | output | 1 | One-cycle pulse: over-long entry met |
| rd_req_valid | output | 1 | Memory read request |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | ADDR_W | Byte address of the requested word |
| rd_rsp_valid | input | 1 | Read data present |
| rd_rsp_data | input | 32 | Read data word |
| seg_valid | output | 1 | Segment offered to the data mover |
| seg_ready | input | 1 | Data mover takes the segment |
| seg_addr | output | 32 | Segment buffer address |
| seg_len | output | 24 | Segment length in bytes |
| seg_irq | output | 1 | Interrupt request flag of the entry |
| seg_action | output | 3 | Action code of the entry |
| seg_end | output | 1 | Entry was marked last |

## Verification
The properties assume that the memory returns exactly one `rd_rsp_valid` beat for each accepted request, in order, and never a beat that was not asked for. The bench's memory model answers each accepted request exactly once, one cycle after the handshake. The properties also assume an 8-byte aligned `table_base` and at least one non-empty entry in any ring table. Every table in the bench is built at an aligned base, and the ring table holds two non-empty entries. Ready stalls on both the read port and the segment port come from fixed patterns, so that the hold properties are exercised under backpressure.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

  localparam int unsigned WORD_W      = 32;
  localparam int unsigned WORD_BYTES  = WORD_W / 8;
  localparam int unsigned ENTRY_BYTES = 2 * WORD_BYTES;
  localparam int unsigned LEN_W       = 24;

  // Packed view of the first entry word, most significant field first.
  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             rsvd;
    logic             ring;
    logic [2:0]       action;
    logic             irq;
    logic             last;
    logic             ok;
  } link_flags_t;

  typedef enum logic [1:0] {
    V_BAD  = 2'd0,
    V_BIG  = 2'd1,
    V_SKIP = 2'd2,
    V_SEND = 2'd3
  } verdict_t;

  function automatic link_flags_t decode_link(input logic [WORD_W-1:0] w);
    return link_flags_t'(w);
  endfunction

  // Invalid beats oversize, oversize beats empty.
  function automatic verdict_t classify(input link_flags_t f,
                                        input logic [LEN_W-1:0] max_len);
    if (!f.ok || f.rsvd) return V_BAD;
    if (f.len > max_len) return V_BIG;
    if (f.len == '0)     return V_SKIP;
    return V_SEND;
  endfunction

endpackage

// File: rtl/sgw_fetch.sv
module sgw_fetch
  import sgw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic [ADDR_W-1:0] kick_addr,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [WORD_W-1:0] rd_rsp_data,
  output logic              entry_valid,
  output logic [WORD_W-1:0] entry_w0,
  output logic [WORD_W-1:0] entry_w1
);

  typedef enum logic [2:0] {
    F_IDLE, F_REQ0, F_WAIT0, F_REQ1, F_WAIT1, F_HAVE
  } fstate_t;

  fstate_t           st;
  logic [ADDR_W-1:0] ent_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= F_IDLE;
      ent_addr <= '0;
      entry_w0 <= '0;
      entry_w1 <= '0;
    end else begin
      unique case (st)
        F_IDLE, F_HAVE: begin
          if (kick) begin
            ent_addr <= kick_addr;
            st       <= F_REQ0;
          end else begin
            st <= F_IDLE;
          end
        end
        F_REQ0:  if (rd_req_ready) st <= F_WAIT0;
        F_WAIT0: if (rd_rsp_valid) begin
          entry_w0 <= rd_rsp_data;
          st       <= F_REQ1;
        end
        F_REQ1:  if (rd_req_ready) st <= F_WAIT1;
        F_WAIT1: if (rd_rsp_valid) begin
          entry_w1 <= rd_rsp_data;
          st       <= F_HAVE;
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  assign rd_req_valid = (st == F_REQ0) || (st == F_REQ1);
  assign rd_req_addr  = (st == F_REQ1) ? ent_addr + ADDR_W'(WORD_BYTES) : ent_addr;
  assign entry_valid  = (st == F_HAVE);

endmodule

// File: rtl/sgw_emit.sv
module sgw_emit
  import sgw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_addr,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              load_irq,
  input  logic [2:0]        load_action,
  input  logic              load_end,
  input  logic              seg_ready,
  output logic              seg_valid,
  output logic [WORD_W-1:0] seg_addr,
  output logic [LEN_W-1:0]  seg_len,
  output logic              seg_irq,
  output logic [2:0]        seg_action,
  output logic              seg_end,
  output logic              seg_taken
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_valid  <= 1'b0;
      seg_addr   <= '0;
      seg_len    <= '0;
      seg_irq    <= 1'b0;
      seg_action <= '0;
      seg_end    <= 1'b0;
    end else if (load) begin
      seg_valid  <= 1'b1;
      seg_addr   <= load_addr;
      seg_len    <= load_len;
      seg_irq    <= load_irq;
      seg_action <= load_action;
      seg_end    <= load_end;
    end else if (seg_taken) begin
      seg_valid <= 1'b0;
    end
  end

  assign seg_taken = seg_valid && seg_ready;

endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
  import sgw_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned MAX_SEG = 32'h0010_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [ADDR_W-1:0] table_base,
  output logic              busy,
  output logic              done,
  output logic              err_invalid,
  output logic              err_oversize,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [WORD_W-1:0] rd_rsp_data,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [WORD_W-1:0] seg_addr,
  output logic [LEN_W-1:0]  seg_len,
  output logic              seg_irq,
  output logic [2:0]        seg_action,
  output logic              seg_end
);

  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_SEG);

  typedef enum logic [1:0] {T_IDLE, T_FETCH, T_SEND} tstate_t;

  tstate_t           t_st;
  logic [ADDR_W-1:0] base_r;
  logic [ADDR_W-1:0] ptr_r;
  logic              abort_pend;

  // Named internal events, also seen by the bound checker.
  logic              entry_valid;
  logic              entry_seen;
  logic              seg_taken;
  logic              step_done;
  logic              stop_now;
  logic              wrap_now;
  logic              start_ok;
  logic              kick;
  logic [ADDR_W-1:0] kick_addr;
  logic              load_seg;
  logic [WORD_W-1:0] w0;
  logic [WORD_W-1:0] w1;
  link_flags_t       cur;
  verdict_t          verdict;

  assign cur     = decode_link(w0);
  assign verdict = classify(cur, MAX_LEN);

  assign entry_seen = entry_valid && (t_st == T_FETCH);
  assign load_seg   = entry_seen && (verdict == V_SEND);
  assign step_done  = (entry_seen && (verdict == V_SKIP)) ||
                      ((t_st == T_SEND) && seg_taken);
  assign wrap_now   = cur.last && cur.ring;
  assign stop_now   = abort_pend || abort || (cur.last && !cur.ring);
  assign start_ok   = (t_st == T_IDLE) && start;
  assign kick       = start_ok || (step_done && !stop_now);
  assign kick_addr  = start_ok ? table_base :
                      wrap_now ? base_r : ptr_r + ADDR_W'(ENTRY_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_st         <= T_IDLE;
      base_r       <= '0;
      ptr_r        <= '0;
      abort_pend   <= 1'b0;
      done         <= 1'b0;
      err_invalid  <= 1'b0;
      err_oversize <= 1'b0;
    end else begin
      done         <= 1'b0;
      err_invalid  <= 1'b0;
      err_oversize <= 1'b0;
      if (abort && (t_st != T_IDLE)) abort_pend <= 1'b1;
      unique case (t_st)
        T_IDLE: if (start) begin
          base_r <= table_base;
          ptr_r  <= table_base;
          t_st   <= T_FETCH;
        end
        T_FETCH: if (entry_seen) begin
          if (verdict == V_BAD) begin
            err_invalid <= 1'b1;
            abort_pend  <= 1'b0;
            t_st        <= T_IDLE;
          end else if (verdict == V_BIG) begin
            err_oversize <= 1'b1;
            abort_pend   <= 1'b0;
            t_st         <= T_IDLE;
          end else if (verdict == V_SEND) begin
            t_st <= T_SEND;
          end
        end
        default: ;
      endcase
      if (step_done) begin
        if (stop_now) begin
          done       <= 1'b1;
          abort_pend <= 1'b0;
          t_st       <= T_IDLE;
        end else begin
          ptr_r <= kick_addr;
          t_st  <= T_FETCH;
        end
      end
    end
  end

  assign busy = (t_st != T_IDLE);

  sgw_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .kick         (kick),
    .kick_addr    (kick_addr),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_data  (rd_rsp_data),
    .entry_valid  (entry_valid),
    .entry_w0     (w0),
    .entry_w1     (w1)
  );

  sgw_emit u_emit (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load_seg),
    .load_addr   (w1),
    .load_len    (cur.len),
    .load_irq    (cur.irq),
    .load_action (cur.action),
    .load_end    (cur.last),
    .seg_ready   (seg_ready),
    .seg_valid   (seg_valid),
    .seg_addr    (seg_addr),
    .seg_len     (seg_len),
    .seg_irq     (seg_irq),
    .seg_action  (seg_action),
    .seg_end     (seg_end),
    .seg_taken   (seg_taken)
  );

endmodule

// File: rtl/sgw_checker.sv
module sgw_checker
  import sgw_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned MAX_SEG = 32'h0010_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err_invalid,
  input logic              err_oversize,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              seg_valid,
  input logic              seg_ready,
  input logic [WORD_W-1:0] seg_addr,
  input logic [LEN_W-1:0]  seg_len,
  input logic              seg_taken,
  input logic              entry_seen
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req_valid && !seg_valid));

  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  assert_entry_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    entry_seen |-> !rd_req_valid);

  assert_seg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len)));

  assert_seg_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seg_taken |=> !seg_valid);

  assert_read_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> !rd_req_valid);

  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err_invalid, err_oversize}));

  assert_idle_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err_invalid || err_oversize) |-> !busy);

  assert_len_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_len <= LEN_W'(MAX_SEG)));

  assert_no_empty_seg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_len != '0));

endmodule

bind sg_chain_walker sgw_checker #(.ADDR_W(ADDR_W), .MAX_SEG(MAX_SEG)) u_sgw_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .err_invalid  (err_invalid),
  .err_oversize (err_oversize),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .seg_valid    (seg_valid),
  .seg_ready    (seg_ready),
  .seg_addr     (seg_addr),
  .seg_len      (seg_len),
  .seg_taken    (seg_taken),
  .entry_seen   (entry_seen)
);

// File: tb/test_sg_chain_walker.sv
module test_sg_chain_walker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        abort = 1'b0;
  logic [31:0] table_base = '0;
  logic        busy, done, err_invalid, err_oversize;
  logic        rd_req_valid, rd_req_ready;
  logic [31:0] rd_req_addr;
  logic        rd_rsp_valid;
  logic [31:0] rd_rsp_data;
  logic        seg_valid, seg_ready;
  logic [31:0] seg_addr;
  logic [23:0] seg_len;
  logic        seg_irq;
  logic [2:0]  seg_action;
  logic        seg_end;

  always #5 clk = ~clk;

  sg_chain_walker i_sg_chain_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .table_base(table_base),
    .busy(busy), .done(done), .err_invalid(err_invalid), .err_oversize(err_oversize),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
    .seg_irq(seg_irq), .seg_action(seg_action), .seg_end(seg_end)
  );

  logic [31:0] mem [0:255];
  int checks = 0;
  int errors = 0;

  logic [31:0] got_addr [0:63];
  logic [23:0] got_len  [0:63];
  logic        got_irq  [0:63];
  logic [2:0]  got_act  [0:63];
  logic        got_end  [0:63];
  logic [31:0] rd_log   [0:63];
  int seg_n = 0, rd_n = 0, done_n = 0, inv_n = 0, big_n = 0;
  bit mem_stall = 1'b0, sink_stall = 1'b0;
  int tick = 0;
  bit rsp_due = 1'b0;
  logic [31:0] rsp_addr = '0;

  // Memory model and segment sink; all driving happens at the falling edge.
  initial begin : responder
    rd_req_ready = 1'b1;
    rd_rsp_valid = 1'b0;
    rd_rsp_data  = '0;
    seg_ready    = 1'b1;
    forever begin
      @(negedge clk);
      tick++;
      rd_rsp_valid = 1'b0;
      if (rsp_due) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = mem[rsp_addr[9:2]];
        rsp_due      = 1'b0;
      end
      rd_req_ready = mem_stall ? (tick % 3 == 0) : 1'b1;
      seg_ready    = sink_stall ? (tick % 4 == 1) : 1'b1;
      if (rd_req_valid && rd_req_ready) begin
        rsp_due  = 1'b1;
        rsp_addr = rd_req_addr;
        if (rd_n < 64) rd_log[rd_n] = rd_req_addr;
        rd_n++;
      end
      if (seg_valid && seg_ready) begin
        if (seg_n < 64) begin
          got_addr[seg_n] = seg_addr;
          got_len[seg_n]  = seg_len;
          got_irq[seg_n]  = seg_irq;
          got_act[seg_n]  = seg_action;
          got_end[seg_n]  = seg_end;
        end
        seg_n++;
      end
      if (done)         done_n++;
      if (err_invalid)  inv_n++;
      if (err_oversize) big_n++;
    end
  end

  // Entry word built from the field layout of R3.
  function automatic logic [31:0] link_word(input int len, input bit v, input bit e,
                                            input bit irq, input int act, input bit ring);
    return {len[23:0], 1'b0, ring, act[2:0], irq, e, v};
  endfunction

  task automatic put(input int base, input int idx, input logic [31:0] w0, input logic [31:0] w1);
    mem[(base >> 2) + 2 * idx]     = w0;
    mem[(base >> 2) + 2 * idx + 1] = w1;
  endtask

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    seg_n = 0; rd_n = 0; done_n = 0; inv_n = 0; big_n = 0;
  endtask

  task automatic kick(input int base);
    @(negedge clk);
    start = 1'b1;
    table_base = base;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 4000; i++) begin
      if (done_n + inv_n + big_n > 0) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_seg(input string req, input int k, input logic [31:0] a, input int len,
                            input bit irq, input int act, input bit e);
    chk(req, $sformatf("seg%0d addr", k), got_addr[k], a);
    chk(req, $sformatf("seg%0d len", k), got_len[k], len);
    chk(req, $sformatf("seg%0d irq", k), got_irq[k], irq);
    chk(req, $sformatf("seg%0d action", k), got_act[k], act);
    chk(req, $sformatf("seg%0d end", k), got_end[k], e);
  endtask

  task automatic build_linear();
    put(32'h100, 0, link_word(32'h40, 1, 0, 1, 5, 0), 32'h8000_1000);
    put(32'h100, 1, link_word(1, 1, 0, 0, 2, 0), 32'h1234_5678);
    put(32'h100, 2, link_word(32'hFFFF, 1, 1, 1, 7, 0), 32'hCAFE_0000);
  endtask

  task automatic check_linear(input string req);
    chk(req, "segment count", seg_n, 3);
    expect_seg(req, 0, 32'h8000_1000, 32'h40, 1, 5, 0);
    expect_seg(req, 1, 32'h1234_5678, 1, 0, 2, 0);
    expect_seg(req, 2, 32'hCAFE_0000, 32'hFFFF, 1, 7, 1);
    chk(req, "read count", rd_n, 6);
    for (int k = 0; k < 6; k++) chk(req, $sformatf("read addr %0d", k), rd_log[k], 32'h100 + 4 * k);
    chk("R5", "done pulses", done_n, 1);
    chk("R5", "busy after end", busy, 0);
  endtask

  task automatic t_reset();
    chk("R1", "busy", busy, 0);
    chk("R1", "rd_req_valid", rd_req_valid, 0);
    chk("R1", "seg_valid", seg_valid, 0);
    chk("R1", "outcome pulses", {done, err_invalid, err_oversize}, 0);
  endtask

  task automatic t_linear();
    clear_log(); build_linear();
    kick(32'h100); wait_end();
    check_linear("R2 R3");
  endtask

  task automatic t_stall();
    clear_log(); mem_stall = 1'b1; sink_stall = 1'b1;
    kick(32'h100); wait_end();
    mem_stall = 1'b0; sink_stall = 1'b0;
    check_linear("R4");
  endtask

  task automatic t_invalid();
    clear_log();
    put(32'h180, 0, link_word(8, 1, 0, 0, 1, 0), 32'h0000_4000);
    put(32'h180, 1, link_word(8, 0, 0, 0, 1, 0), 32'h0000_5000);
    put(32'h180, 2, link_word(8, 1, 1, 0, 1, 0), 32'h0000_6000);
    kick(32'h180); wait_end();
    chk("R6", "err_invalid pulses", inv_n, 1);
    chk("R6", "done pulses", done_n, 0);
    chk("R6", "segment count", seg_n, 1);
    chk("R6", "read count", rd_n, 4);
    chk("R6", "busy", busy, 0);
    clear_log();
    put(32'h1C0, 0, link_word(8, 1, 1, 0, 0, 0) | 32'h80, 32'h0000_7000);
    kick(32'h1C0); wait_end();
    chk("R6", "reserved bit err_invalid", inv_n, 1);
    chk("R6", "reserved bit segments", seg_n, 0);
  endtask

  task automatic t_oversize();
    clear_log();
    put(32'h240, 0, link_word(32'h100000, 1, 0, 0, 3, 0), 32'h0001_0000);
    put(32'h240, 1, link_word(32'h100001, 1, 1, 0, 3, 0), 32'h0002_0000);
    kick(32'h240); wait_end();
    chk("R7", "segment count", seg_n, 1);
    chk("R7", "max length passed", got_len[0], 32'h100000);
    chk("R7", "err_oversize pulses", big_n, 1);
    chk("R7", "done pulses", done_n, 0);
    chk("R7", "read count", rd_n, 4);
  endtask

  task automatic t_skip();
    clear_log();
    put(32'h280, 0, link_word(0, 1, 0, 0, 0, 0), 32'h0000_A000);
    put(32'h280, 1, link_word(32'h20, 1, 0, 0, 4, 0), 32'h0000_B000);
    put(32'h280, 2, link_word(0, 1, 1, 0, 0, 0), 32'h0000_C000);
    kick(32'h280); wait_end();
    chk("R8", "segment count", seg_n, 1);
    chk("R8", "kept segment addr", got_addr[0], 32'h0000_B000);
    chk("R8", "read count", rd_n, 6);
    chk("R8", "done pulses", done_n, 1);
  endtask

  task automatic t_ring_abort();
    int reads_at_end;
    clear_log();
    put(32'h300, 0, link_word(32'h10, 1, 0, 0, 1, 0), 32'h0000_AAA0);
    put(32'h300, 1, link_word(32'h20, 1, 1, 0, 6, 1), 32'h0000_BBB0);
    kick(32'h300);
    for (int i = 0; i < 2000; i++) begin
      if (seg_n >= 5) break;
      @(negedge clk);
    end
    chk("R9", "no early done", done_n, 0);
    chk("R9", "wrap read addr", rd_log[4], 32'h300);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    wait_end();
    chk("R10", "done pulses", done_n, 1);
    chk("R10", "enough segments", seg_n >= 5, 1);
    for (int k = 0; k < 6; k++)
      if (k < seg_n)
        chk("R9", $sformatf("ring seg%0d addr", k), got_addr[k],
            (k % 2 == 1) ? 32'h0000_BBB0 : 32'h0000_AAA0);
    reads_at_end = rd_n;
    repeat (20) @(negedge clk);
    chk("R10", "no reads after abort", rd_n, reads_at_end);
    chk("R10", "idle after abort", busy, 0);
  endtask

  task automatic t_busy_start();
    clear_log();
    kick(32'h100);
    @(negedge clk);
    start = 1'b1; table_base = 32'h3C0;
    @(negedge clk);
    start = 1'b0;
    wait_end();
    check_linear("R11");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_linear();
    t_stall();
    t_invalid();
    t_oversize();
    t_skip();
    t_ring_abort();
    t_busy_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule